// File: doc/BRIEF.md
# Three-Channel Converter Sample Conditioner with Receive Gain

This block takes the raw output of a 12-bit converter that cycles through three inputs: quadrature (Q), in-phase (I) and audio. It removes the slowly moving DC offset of each input, sums a burst of corrected samples into one result per channel, and keeps a slow magnitude estimate for each channel. From the larger of the I and Q magnitudes it derives a receive gain factor. A multi-cycle divider computes this factor. The factor holds its value while the radio transmits.

Samples enter on a valid/ready stream. A sample moves on the clock edge where `s_valid` and `s_ready` are both high. The source must hold the sample and its `s_sof` flag until that edge. The block lowers `s_ready` for exactly one cycle after each burst closes, while it updates the levels. `s_ready` is high in every other cycle, so the block never stalls the source for longer than that. The block does not wait for the gain division to finish. If a new burst starts while a division is still pending or running, the block counts an overrun.

Top module: `adc_cond_agc`

## Requirements
- R1: After reset, all results read 0, all levels read 2560 (10·256), gain reads TOP (1500 by default), the overrun count reads 0, `res_valid` and `gain_done` are low, and `s_ready` is high.
- R2: A burst is 24 accepted samples. Accepted sample k of a burst (k = 0..23) belongs to channel k mod 3, where 0 is Q, 1 is I and 2 is audio. The burst closes on its 24th accepted sample.
- R3: Each channel has a bias tracker b. It starts at 2048·256 and is updated on each of that channel's samples x as b := b + x − floor(b/256). The channel result is the sum of x − floor(b/256) over the burst, using the already updated b. The result is a signed two's complement value. All three results appear together one cycle after the closing edge, and `res_valid` is high for that one cycle.
- R4: One cycle after the results appear, each level L becomes floor((1023·L + |result|·256)/1024), computed exactly with no overflow.
- R5: Let d = floor(max(L_I, L_Q)/256), using the levels just updated. The gain becomes floor(TOP/d), or TOP when d is 0, and `gain_done` pulses for one cycle. When d is 0 the pulse comes 2 cycles after the closing edge. Otherwise it comes 18 cycles after it, because the divider takes 16 cycles.
- R6: If `tx_en` is high on the edge where the levels update, no gain computation takes place: gain keeps its value and `gain_done` stays low.
- R7: An accepted sample with `s_sof` = 1 starts a new burst as its first Q sample. Partial sums of the abandoned burst are discarded. The bias trackers keep their history.
- R8: `s_ready` is low for exactly one cycle after a closing edge and high otherwise. A sample offered in the low cycle is not taken and must be held.
- R9: When the first sample of a burst is accepted while a gain computation is pending or in progress, the 8-bit overrun count increments, wrapping at 256.
- R10: Cycles without an accepted sample change no result, tracker or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample may be taken |
| s_data | input | 12 | Unsigned converter sample |
| s_sof | input | 1 | Sample starts a new burst |
| tx_en | input | 1 | Transmit active, freezes the gain |
| res_q | output | 16 | Q burst result, signed |
| res_i | output | 16 | I burst result, signed |
| res_a | output | 16 | Audio burst result, signed |
| res_valid | output | 1 | Results updated this cycle |
| lvl_q | output | 24 | Q level, 8 fractional bits |
| lvl_i | output | 24 | I level, 8 fractional bits |
| lvl_a | output | 24 | Audio level, 8 fractional bits |
| gain | output | 16 | Receive gain factor |
| gain_done | output | 1 | Gain computation finished |
| ovr_cnt | output | 8 | Overrun count |

## Verification
The hardest branch to reach is the zero divisor. The larger of the I and Q levels must fall below 256, but it starts at 2560 and the filter only lets it fall by one part in 1024 per burst. To get there, the stimulus feeds about 1600 back-to-back bursts of a constant mid-scale sample. The bias trackers are already settled on that value, so every result is exactly zero. The same back-to-back stream starts each burst during a running division, which drives the overrun count. A behavioural model tracks the outcome on every cycle.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;
  localparam int NUM_CH       = 3;
  localparam int CH_Q         = 0;
  localparam int CH_I         = 1;
  localparam int CH_A         = 2;
  localparam int BIAS_FRAC    = 8;
  localparam int LVL_FRAC     = 8;
  localparam int LVL_POLE     = 10;
  localparam int LVL_INIT_INT = 10;
endpackage

// File: rtl/adc_bias_acc.sv
module adc_bias_acc
  import adc_cond_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int RES_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    restart,
  input  logic                    close,
  input  logic [SMP_W-1:0]        smp,
  output logic signed [RES_W-1:0] res
);
  localparam int BIAS_W = SMP_W + BIAS_FRAC + 1;
  localparam int CORR_W = SMP_W + 1;
  localparam logic [BIAS_W-1:0] BIAS_INIT = BIAS_W'(1) << (SMP_W - 1 + BIAS_FRAC);

  logic [BIAS_W-1:0]        bias_q, bias_nx;
  logic signed [CORR_W-1:0] corr;
  logic signed [RES_W-1:0]  corr_ext, acc_q, acc_base, acc_nx;

  // tracker steps first, then the corrected sample uses the fresh value
  always_comb begin
    bias_nx  = bias_q + BIAS_W'(smp) - (bias_q >> BIAS_FRAC);
    corr     = $signed({1'b0, smp}) - $signed(CORR_W'(bias_nx >> BIAS_FRAC));
    corr_ext = RES_W'(corr);
    acc_base = restart ? '0 : acc_q;
    acc_nx   = acc_base + (smp_en ? corr_ext : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bias_q <= BIAS_INIT;
      acc_q  <= '0;
      res    <= '0;
    end else begin
      if (smp_en) bias_q <= bias_nx;
      if (close) begin
        res   <= acc_nx;
        acc_q <= '0;
      end else if (smp_en || restart) begin
        acc_q <= acc_nx;
      end
    end
  end

  // R3: tracker settles below full scale times 256
  assert_bias_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bias_q[BIAS_W-1] == 1'b0);
endmodule

// File: rtl/adc_level_filt.sv
module adc_level_filt
  import adc_cond_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int LVL_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [RES_W-1:0] res,
  output logic [LVL_W-1:0]        lvl
);
  localparam int SUM_W = LVL_W + LVL_POLE;
  localparam logic [LVL_W-1:0] LVL_INIT = LVL_W'(LVL_INIT_INT) << LVL_FRAC;

  logic [RES_W-1:0] mag;
  logic [LVL_W-1:0] mag_sh;
  logic [SUM_W-1:0] sum;

  always_comb begin
    mag    = res[RES_W-1] ? RES_W'(-res) : RES_W'(res);
    mag_sh = LVL_W'(mag) << LVL_FRAC;
    sum    = (SUM_W'(lvl) << LVL_POLE) - SUM_W'(lvl) + SUM_W'(mag_sh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  lvl <= LVL_INIT;
    else if (en) lvl <= LVL_W'(sum >> LVL_POLE);
  end

  // R4: new level never exceeds the larger of old level and scaled input
  assert_level_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> (lvl <= $past(lvl) || lvl <= $past(mag_sh)));
endmodule

// File: rtl/agc_divider.sv
module agc_divider #(
  parameter int DEN_W = 16,
  parameter int Q_W   = 16,
  parameter int TOP   = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEN_W-1:0] den,
  output logic [Q_W-1:0]   quo,
  output logic             done,
  output logic             busy
);
  localparam int CNT_W = (Q_W > 1) ? $clog2(Q_W) : 1;
  localparam int PW    = DEN_W + Q_W;
  localparam logic [Q_W-1:0] TOP_V = Q_W'(TOP);

  logic [Q_W-1:0]   work_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             qbit;
  logic [PW-1:0]    prod;

  always_comb begin
    rem_sh  = {rem_q, work_q[Q_W-1]};
    qbit    = rem_sh >= {1'b0, den_q};
    rem_sub = qbit ? (rem_sh - {1'b0, den_q}) : rem_sh;
    prod    = PW'(quo) * PW'(den_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo    <= TOP_V;
      done   <= 1'b0;
      busy   <= 1'b0;
      work_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (den == '0) begin
          quo   <= TOP_V;
          done  <= 1'b1;
          den_q <= '0;
        end else begin
          busy   <= 1'b1;
          cnt_q  <= '0;
          rem_q  <= '0;
          work_q <= TOP_V;
          den_q  <= den;
        end
      end else if (busy) begin
        work_q <= {work_q[Q_W-2:0], qbit};
        rem_q  <= DEN_W'(rem_sub);
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(Q_W - 1)) begin
          busy <= 1'b0;
          quo  <= {work_q[Q_W-2:0], qbit};
          done <= 1'b1;
        end
      end
    end
  end

  // R5: finished quotient is the floor of TOP over the divisor
  assert_quotient_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && den_q != '0) |-> (prod <= PW'(TOP) && (PW'(TOP) - prod) < PW'(den_q)));

  // R9: the sequencer never restarts a running division
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/adc_cond_agc.sv
module adc_cond_agc
  import adc_cond_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int ROUNDS  = 8,
  parameter int AGC_TOP = 1500,
  parameter int GAIN_W  = 16,
  parameter int OVR_W   = 8,
  localparam int RES_W  = SMP_W + 1 + $clog2(ROUNDS),
  localparam int LVL_W  = RES_W + LVL_FRAC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [SMP_W-1:0]        s_data,
  input  logic                    s_sof,
  input  logic                    tx_en,
  output logic signed [RES_W-1:0] res_q,
  output logic signed [RES_W-1:0] res_i,
  output logic signed [RES_W-1:0] res_a,
  output logic                    res_valid,
  output logic [LVL_W-1:0]        lvl_q,
  output logic [LVL_W-1:0]        lvl_i,
  output logic [LVL_W-1:0]        lvl_a,
  output logic [GAIN_W-1:0]       gain,
  output logic                    gain_done,
  output logic [OVR_W-1:0]        ovr_cnt
);
  localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam int DEN_W = LVL_W - LVL_FRAC;

  logic [1:0]              ch_q, cur_ch;
  logic [RND_W-1:0]        rnd_q;
  logic                    fire, first, last;
  logic                    lvl_pend_q, div_pend_q, div_busy;
  logic [LVL_W-1:0]        lvl_max;
  logic [DEN_W-1:0]        den;
  logic signed [RES_W-1:0] res_w [NUM_CH];
  logic [LVL_W-1:0]        lvl_w [NUM_CH];

  assign s_ready = !lvl_pend_q;

  always_comb begin
    fire    = s_valid && s_ready;
    first   = s_sof || (ch_q == 2'd0 && rnd_q == '0);
    cur_ch  = s_sof ? 2'd0 : ch_q;
    last    = !s_sof && ch_q == 2'(NUM_CH - 1) && rnd_q == RND_W'(ROUNDS - 1);
    lvl_max = (lvl_w[CH_I] > lvl_w[CH_Q]) ? lvl_w[CH_I] : lvl_w[CH_Q];
    den     = DEN_W'(lvl_max >> LVL_FRAC);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    adc_bias_acc #(.SMP_W(SMP_W), .RES_W(RES_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_en  (fire && cur_ch == 2'(c)),
      .restart (fire && first),
      .close   (fire && last),
      .smp     (s_data),
      .res     (res_w[c])
    );
    adc_level_filt #(.RES_W(RES_W), .LVL_W(LVL_W)) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (lvl_pend_q),
      .res   (res_w[c]),
      .lvl   (lvl_w[c])
    );
  end

  agc_divider #(.DEN_W(DEN_W), .Q_W(GAIN_W), .TOP(AGC_TOP)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_pend_q),
    .den   (den),
    .quo   (gain),
    .done  (gain_done),
    .busy  (div_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q       <= '0;
      rnd_q      <= '0;
      lvl_pend_q <= 1'b0;
      div_pend_q <= 1'b0;
      res_valid  <= 1'b0;
      ovr_cnt    <= '0;
    end else begin
      res_valid  <= fire && last;
      lvl_pend_q <= fire && last;
      div_pend_q <= lvl_pend_q && !tx_en;
      if (fire) begin
        if (last) begin
          ch_q  <= '0;
          rnd_q <= '0;
        end else if (cur_ch == 2'(NUM_CH - 1)) begin
          ch_q  <= '0;
          rnd_q <= rnd_q + 1'b1;
        end else begin
          ch_q <= cur_ch + 2'd1;
          if (s_sof) rnd_q <= '0;
        end
        if (first && (div_pend_q || div_busy)) ovr_cnt <= ovr_cnt + 1'b1;
      end
    end
  end

  assign res_q = res_w[CH_Q];
  assign res_i = res_w[CH_I];
  assign res_a = res_w[CH_A];
  assign lvl_q = lvl_w[CH_Q];
  assign lvl_i = lvl_w[CH_I];
  assign lvl_a = lvl_w[CH_A];

  // R6: gain moves only on the edge that ends a pending or running division
  assert_gain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(div_pend_q) && !$past(div_busy)) |-> $stable(gain));

  // R8: the result-publish cycle is the single stall cycle
  assert_stall_on_publish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !s_ready);
endmodule

// File: tb/sim_adc_cond_agc.sv
module sim_adc_cond_agc;
  localparam int TOP = 1500;

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_sof, tx_en;
  logic [11:0] s_data;
  logic s_ready, res_valid, gain_done;
  logic signed [15:0] res_q, res_i, res_a;
  logic [23:0] lvl_q, lvl_i, lvl_a;
  logic [15:0] gain;
  logic [7:0]  ovr_cnt;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  adc_cond_agc u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .tx_en(tx_en),
    .res_q(res_q), .res_i(res_i), .res_a(res_a), .res_valid(res_valid),
    .lvl_q(lvl_q), .lvl_i(lvl_i), .lvl_a(lvl_a),
    .gain(gain), .gain_done(gain_done), .ovr_cnt(ovr_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  longint m_b[3], m_acc[3], m_res[3], m_lvl[3];
  longint m_gain, m_qn;
  int     m_pos, m_divcnt, m_ovr;
  bit     m_lvlpend, m_divpend, m_rvalid, m_done;

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_b[c] = 2048 * 256; m_acc[c] = 0; m_res[c] = 0; m_lvl[c] = 2560;
      end
      m_gain = TOP; m_qn = 0; m_pos = 0; m_divcnt = 0; m_ovr = 0;
      m_lvlpend = 0; m_divpend = 0; m_rvalid = 0; m_done = 0;
    end else begin
      bit pre_busy, take;
      longint d, x;
      int ch;
      pre_busy = m_divpend || (m_divcnt > 0);
      take = s_valid && !m_lvlpend;
      m_done = 0;
      m_rvalid = 0;
      if (m_divcnt > 0) begin
        m_divcnt--;
        if (m_divcnt == 0) begin m_gain = m_qn; m_done = 1; end
      end
      if (m_divpend) begin
        m_divpend = 0;
        d = ((m_lvl[0] > m_lvl[1]) ? m_lvl[0] : m_lvl[1]) / 256;
        if (d == 0) begin m_gain = TOP; m_done = 1; end
        else begin m_qn = TOP / d; m_divcnt = 16; end
      end
      if (m_lvlpend) begin
        m_lvlpend = 0;
        for (int c = 0; c < 3; c++)
          m_lvl[c] = (1023 * m_lvl[c] + labs(m_res[c]) * 256) / 1024;
        m_divpend = !tx_en;
      end
      if (take) begin
        if (s_sof) begin
          m_pos = 0;
          for (int c = 0; c < 3; c++) m_acc[c] = 0;
        end
        if (m_pos == 0 && pre_busy) m_ovr = (m_ovr + 1) % 256;
        ch = m_pos % 3;
        x = longint'(s_data);
        m_b[ch] = m_b[ch] + x - (m_b[ch] / 256);
        m_acc[ch] = m_acc[ch] + x - (m_b[ch] / 256);
        m_pos++;
        if (m_pos == 24) begin
          for (int c = 0; c < 3; c++) begin m_res[c] = m_acc[c]; m_acc[c] = 0; end
          m_pos = 0; m_rvalid = 1; m_lvlpend = 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 s_ready", s_ready, !m_lvlpend);
      chk("R2 R3 R7 R10 res_q", res_q, m_res[0]);
      chk("R2 R3 R7 R10 res_i", res_i, m_res[1]);
      chk("R2 R3 R7 R10 res_a", res_a, m_res[2]);
      chk("R3 res_valid", res_valid, m_rvalid);
      chk("R4 R10 lvl_q", lvl_q, m_lvl[0]);
      chk("R4 R10 lvl_i", lvl_i, m_lvl[1]);
      chk("R4 R10 lvl_a", lvl_a, m_lvl[2]);
      chk("R5 R6 gain", gain, m_gain);
      chk("R5 R6 gain_done", gain_done, m_done);
      chk("R9 ovr_cnt", ovr_cnt, m_ovr);
    end
  end

  task automatic put(input logic [11:0] d, input logic sof);
    bit took;
    took = 0;
    while (!took) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_sof = sof;
      took = s_ready;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b0; s_sof = 1'b0;
    end
  endtask

  task automatic burst_rand(input int lo, input int hi, input int gapmax, input bit sof0);
    for (int k = 0; k < 24; k++) begin
      put(12'($urandom_range(hi, lo)), (k == 0) && sof0);
      if (gapmax > 0) idle($urandom_range(gapmax, 0));
    end
  endtask

  longint exp_g, dmax;
  logic [15:0] g0;

  initial begin
    s_valid = 0; s_data = '0; s_sof = 0; tx_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_q", res_q, 0);
    chk("R1 res_a", res_a, 0);
    chk("R1 lvl_i", lvl_i, 2560);
    chk("R1 gain", gain, TOP);
    chk("R1 ovr_cnt", ovr_cnt, 0);
    chk("R1 s_ready", s_ready, 1);
    chk("R1 res_valid", res_valid, 0);

    // silent back-to-back bursts: levels decay to a zero divisor
    for (int b = 0; b < 1600; b++)
      for (int k = 0; k < 24; k++) put(12'd2048, 1'b0);
    idle(40);
    chk("R5 level below one (precondition)", (lvl_i < 256 && lvl_q < 256), 1);
    chk("R5 zero divisor gives TOP", gain, TOP);
    chk("R9 overruns seen", (ovr_cnt != 0), 1);

    // varied signals with gaps
    for (int b = 0; b < 12; b++) burst_rand(0, 4095, 3, 1'b0);
    idle(40);
    dmax = ((lvl_i > lvl_q) ? lvl_i : lvl_q) / 256;
    exp_g = (dmax == 0) ? TOP : TOP / dmax;
    chk("R5 gain from port levels", gain, exp_g);

    // back-to-back with a nonzero divisor
    for (int b = 0; b < 4; b++) burst_rand(1500, 2600, 0, 1'b0);
    idle(40);

    // transmit freezes the gain
    g0 = gain;
    tx_en = 1'b1;
    for (int b = 0; b < 3; b++) burst_rand(0, 4095, 1, 1'b0);
    idle(40);
    chk("R6 gain frozen in transmit", gain, g0);
    tx_en = 1'b0;

    // restart mid-burst
    for (int k = 0; k < 10; k++) put(12'($urandom_range(4095, 0)), 1'b0);
    burst_rand(200, 3900, 2, 1'b1);
    for (int k = 0; k < 5; k++) put(12'($urandom_range(4095, 0)), 1'b0);
    burst_rand(0, 4095, 0, 1'b1);
    idle(40);

    // long gaps inside bursts
    for (int b = 0; b < 3; b++) burst_rand(0, 4095, 8, 1'b0);
    idle(40);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", 150000, 150000);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule